// File: doc/BRIEF.md
# Indexed Clock-Gate Set/Clear Register

This block keeps a 64-bit clock-disable vector with one bit for each peripheral, and it drives the 64 matching clock-enable outputs. Software changes the vector through two write-only ports and never needs a read-modify-write sequence. A write to the set port disables one peripheral's clock, and a write to the clear port enables one. Each write carries a 7-bit index. An index of 64 or higher acts on the whole vector at once.

The register bus is synchronous. Each port has its own write strobe and its own 8-bit data input, so one cycle can carry both a set and a clear. Reads are combinational from the stored vector. The vector is split into two 32-bit words. The two port addresses read back as zero.

Top module: `cg_index_reg`

## Requirements
- R1: After reset the vector is all zeroes, so every bit of `clkEn` is 1 and both vector words read 0.
- R2: A clear write whose index (data bits 6..0) is 0 to 63 zeroes only the vector bit at that index. That peripheral's `clkEn` becomes 1 and every other bit keeps its value.
- R3: A clear write whose index is 64 to 127 zeroes the whole vector, so all of `clkEn` becomes 1.
- R4: Bit 7 of the write data on either port has no effect on the result.
- R5: A set write whose index is 0 to 63 sets only the vector bit at that index, so that peripheral's `clkEn` becomes 0.
- R6: A set write whose index is 64 to 127 sets every vector bit, so all of `clkEn` becomes 0.
- R7: When a set and a clear arrive in the same cycle and touch the same bit, that bit ends cleared. A global clear in the same cycle as any set leaves the vector all zeroes.
- R8: When a set and a non-global clear arrive in the same cycle and target different bits, both bits are updated.
- R9: `clkEn[i]` is the inverse of vector bit i. Read address 0 returns vector bits 31..0 and read address 1 returns bits 63..32.
- R10: Read addresses 2 (set port) and 3 (clear port) always return 0.
- R11: An update appears on the clock edge that samples the strobe. In a cycle with no strobe the vector holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setWrEn | input | 1 | Write strobe for the set port |
| setWrData | input | 8 | Set port data; bits 6..0 are the index |
| clrWrEn | input | 1 | Write strobe for the clear port |
| clrWrData | input | 8 | Clear port data; bits 6..0 are the index |
| rdAddr | input | 2 | Read select: 0 low word, 1 high word, 2 set port, 3 clear port |
| rdData | output | 32 | Read data |
| clkEn | output | 64 | Per-peripheral clock enables |

## Verification
Directed writes hit the edge indices 0, 63, 64 and 127. They separate single-bit decoding from the global range and find the point where the two ranges meet. Writes with bit 7 set and the same index show that the reserved bit does nothing. Same-cycle set/clear pairs are applied to the same bit, to different bits and against a global clear, which separates the clear-wins priority from independent updates. Several thousand seeded random single and paired writes, with idle cycles mixed in, are checked after every operation against a model in the bench through both read words and the enable outputs.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef struct packed {
    logic doClr;
    logic clrAll;
    logic doSet;
    logic setAll;
  } gateCmd_t;
endpackage

// File: rtl/cg_ctrl.sv
module cg_ctrl import cg_pkg::*; #(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 7,
  localparam int SEL_W     = $clog2(NUM_PERIPH)
) (
  input  logic              setWrEn,
  input  logic [DATA_W-1:0] setWrData,
  input  logic              clrWrEn,
  input  logic [DATA_W-1:0] clrWrData,
  output gateCmd_t          cmd,
  output logic [SEL_W-1:0]  setSel,
  output logic [SEL_W-1:0]  clrSel
);
  logic [IDX_W-1:0] setIdx;
  logic [IDX_W-1:0] clrIdx;
  logic unusedHi;

  assign setIdx = setWrData[IDX_W-1:0];
  assign clrIdx = clrWrData[IDX_W-1:0];
  // reserved upper data bits are deliberately dropped
  assign unusedHi = ^{setWrData[DATA_W-1:IDX_W], clrWrData[DATA_W-1:IDX_W]};

  always_comb begin
    cmd.doSet  = setWrEn;
    cmd.doClr  = clrWrEn;
    cmd.setAll = setWrEn && (32'(setIdx) >= NUM_PERIPH);
    cmd.clrAll = clrWrEn && (32'(clrIdx) >= NUM_PERIPH);
    setSel     = setIdx[SEL_W-1:0];
    clrSel     = clrIdx[SEL_W-1:0];
  end
endmodule

// File: rtl/cg_vector.sv
module cg_vector import cg_pkg::*; #(
  parameter int NUM_PERIPH = 64,
  localparam int SEL_W     = $clog2(NUM_PERIPH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gateCmd_t              cmd,
  input  logic [SEL_W-1:0]      setSel,
  input  logic [SEL_W-1:0]      clrSel,
  output logic [NUM_PERIPH-1:0] offVec
);
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
    logic clrHit;
    logic setHit;
    assign clrHit = cmd.doClr && (cmd.clrAll || clrSel == SEL_W'(i));
    assign setHit = cmd.doSet && (cmd.setAll || setSel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)       offVec[i] <= 1'b0;
      else if (clrHit) offVec[i] <= 1'b0;
      else if (setHit) offVec[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/cg_readmux.sv
module cg_readmux #(
  parameter int NUM_PERIPH = 64,
  parameter int RD_W       = 32,
  localparam int NUM_WORDS = NUM_PERIPH / RD_W,
  localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int RA_W      = WSEL_W + 1
) (
  input  logic [NUM_PERIPH-1:0] offVec,
  input  logic [RA_W-1:0]       rdAddr,
  output logic [RD_W-1:0]       rdData
);
  logic [RD_W-1:0] words [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words[w] = offVec[w*RD_W +: RD_W];
  end

  always_comb begin
    if (rdAddr[RA_W-1]) rdData = '0;
    else                rdData = words[rdAddr[WSEL_W-1:0]];
  end
endmodule

// File: rtl/cg_index_reg.sv
module cg_index_reg import cg_pkg::*; #(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 7,
  parameter int RD_W       = 32,
  localparam int SEL_W     = $clog2(NUM_PERIPH),
  localparam int RA_W      = $clog2(NUM_PERIPH / RD_W) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  setWrEn,
  input  logic [DATA_W-1:0]     setWrData,
  input  logic                  clrWrEn,
  input  logic [DATA_W-1:0]     clrWrData,
  input  logic [RA_W-1:0]       rdAddr,
  output logic [RD_W-1:0]       rdData,
  output logic [NUM_PERIPH-1:0] clkEn
);
  gateCmd_t             cmd;
  logic [SEL_W-1:0]     setSel;
  logic [SEL_W-1:0]     clrSel;
  logic [NUM_PERIPH-1:0] offVec;

  cg_ctrl #(.NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W), .IDX_W(IDX_W)) ctrl_i (
    .setWrEn(setWrEn), .setWrData(setWrData),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .cmd(cmd), .setSel(setSel), .clrSel(clrSel)
  );

  cg_vector #(.NUM_PERIPH(NUM_PERIPH)) vec_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .setSel(setSel), .clrSel(clrSel), .offVec(offVec)
  );

  cg_readmux #(.NUM_PERIPH(NUM_PERIPH), .RD_W(RD_W)) rd_i (
    .offVec(offVec), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign clkEn = ~offVec;
endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
  parameter int NUM_PERIPH = 64,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 7,
  parameter int RD_W       = 32,
  localparam int SEL_W     = $clog2(NUM_PERIPH),
  localparam int RA_W      = $clog2(NUM_PERIPH / RD_W) + 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  setWrEn,
  input logic [DATA_W-1:0]     setWrData,
  input logic                  clrWrEn,
  input logic [DATA_W-1:0]     clrWrData,
  input logic [RA_W-1:0]       rdAddr,
  input logic [RD_W-1:0]       rdData,
  input logic [NUM_PERIPH-1:0] clkEn
);
  logic clrGlobal;
  logic setGlobal;
  assign clrGlobal = 32'(clrWrData[IDX_W-1:0]) >= NUM_PERIPH;
  assign setGlobal = 32'(setWrData[IDX_W-1:0]) >= NUM_PERIPH;

  assert_global_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    clrWrEn && clrGlobal |=> &clkEn);

  assert_single_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    clrWrEn && !clrGlobal |=> clkEn[$past(clrWrData[SEL_W-1:0])]);

  assert_single_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    setWrEn && !setGlobal && !clrWrEn |=> !clkEn[$past(setWrData[SEL_W-1:0])]);

  assert_global_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    setWrEn && setGlobal && !clrWrEn |=> clkEn == '0);

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !setWrEn && !clrWrEn |=> $stable(clkEn));

  assert_port_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdAddr[RA_W-1] |-> rdData == '0);
endmodule

bind cg_index_reg cg_checker #(
  .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W), .IDX_W(IDX_W), .RD_W(RD_W)
) chk_i (
  .clk(clk), .rstN(rstN), .setWrEn(setWrEn), .setWrData(setWrData),
  .clrWrEn(clrWrEn), .clrWrData(clrWrData), .rdAddr(rdAddr),
  .rdData(rdData), .clkEn(clkEn)
);

// File: tb/cg_index_reg_tb.sv
module cg_index_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        setWrEn, clrWrEn;
  logic [7:0]  setWrData, clrWrData;
  logic [1:0]  rdAddr;
  logic [31:0] rdData;
  logic [63:0] clkEn;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  cg_index_reg dut_i (
    .clk(clk), .rstN(rstN), .setWrEn(setWrEn), .setWrData(setWrData),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData), .rdAddr(rdAddr),
    .rdData(rdData), .clkEn(clkEn)
  );

  function automatic logic [63:0] nextVec(logic [63:0] cur, logic sEn, logic [7:0] sV,
                                          logic cEn, logic [7:0] cV);
    logic [63:0] r = cur;
    if (sEn) begin
      if (sV[6]) r = '1; else r[sV[5:0]] = 1'b1;
    end
    if (cEn) begin
      if (cV[6]) r = '0; else r[cV[5:0]] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare outputs and all read addresses against the model, in the low clock phase
  task automatic checkAll(string tag);
    logic [31:0] lo, hi, p2, p3;
    rdAddr = 2'd0; #1 lo = rdData;
    rdAddr = 2'd1; #1 hi = rdData;
    rdAddr = 2'd2; #1 p2 = rdData;
    rdAddr = 2'd3; #1 p3 = rdData;
    chk({tag, " clkEn"}, clkEn, ~model);
    chk({tag, " R9 words"}, {hi, lo}, model);
    chk({tag, " R10 ports"}, {32'(p2), 32'(p3)}, 64'd0);
  endtask

  task automatic apply(string tag, logic sEn, logic [7:0] sV, logic cEn, logic [7:0] cV);
    @(negedge clk);
    setWrEn = sEn; setWrData = sV; clrWrEn = cEn; clrWrData = cV;
    @(negedge clk);
    setWrEn = 1'b0; clrWrEn = 1'b0;
    setWrData = 8'($urandom); clrWrData = 8'($urandom);
    model = nextVec(model, sEn, sV, cEn, cV);
    checkAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; setWrEn = 0; clrWrEn = 0; setWrData = '0; clrWrData = '0; rdAddr = '0;
    model = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1 reset");

    apply("R6 set all", 1, 8'd64, 0, 8'd0);
    apply("R2 clear 0", 0, 8'd0, 1, 8'd0);
    apply("R2 clear 63", 0, 8'd0, 1, 8'd63);
    apply("R4 clear bit7 idx5", 0, 8'd0, 1, 8'h85);
    apply("R3 clear 127", 0, 8'd0, 1, 8'd127);
    apply("R5 set 63", 1, 8'd63, 0, 8'd0);
    apply("R5 set 0", 1, 8'd0, 0, 8'd0);
    apply("R4 set bit7 idx31", 1, 8'h9F, 0, 8'd0);
    apply("R7 same bit", 1, 8'd40, 1, 8'd40);
    apply("R8 different bits", 1, 8'd33, 1, 8'd0);
    apply("R6 set 127", 1, 8'd127, 0, 8'd0);
    apply("R7 global clear beats set", 1, 8'd12, 1, 8'd64);
    apply("R7 global clear beats global set", 1, 8'd100, 1, 8'd70);
    apply("R8 global set with single clear", 1, 8'd64, 1, 8'd17);
    apply("R11 idle", 0, 8'd3, 0, 8'd9);

    for (int n = 0; n < 3000; n++) begin
      logic sEn, cEn;
      logic [7:0] sV, cV;
      sEn = 1'($urandom);
      cEn = 1'($urandom);
      sV = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(64, 255)) : {1'($urandom), 1'b0, 6'($urandom)};
      cV = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(64, 255)) : {1'($urandom), 1'b0, 6'($urandom)};
      if ($urandom_range(0, 7) == 0) cV = sV;
      apply("R2 R5 R7 R8 R11 random", sEn, sV, cEn, cV);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule